// File: doc/BRIEF.md
# CPU Stack Frame Sequencer

This block owns the 16-bit stack pointer of a small CPU. It moves register contents to and from a byte-wide memory port, one byte per clock. The instruction decoder hands it one of six request types: subroutine call, subroutine return, interrupt entry, return from interrupt, single-byte push and single-byte pull. The block then runs the whole frame without further help.

While a frame runs it drives the memory address, the write data and a write or read strobe. On pulls it captures the returned bytes into the restored program counter, accumulator, index-low and condition-code outputs. It raises a one-cycle done pulse after the last byte. Requests that arrive while a frame is in flight are dropped.

Software can move the stack with a load input, for example out of page zero. Every stack access is compared against a fixed RAM window, and a sticky error flag records any access that falls outside it.

Top module: `stk_frame_seq`

## Requirements
- R1: After reset, sp_out is 0x00FF, busy, done, mem_we and mem_re are 0, and range_err is 0.
- R2: req_kind encodes 1 = call, 2 = return, 3 = interrupt entry, 4 = return from interrupt, 5 = push accumulator, 6 = pull accumulator. Any other value does nothing. A request is taken on a clock edge where req_valid is 1, busy is 0 and sp_load is 0. A request raised while busy is 1 causes no memory transfer, no change of sp_out and no extra done.
- R3: A push byte is written (mem_we = 1) at address sp_out. The pointer then drops by one. Transfers begin the cycle after acceptance and run at one byte per cycle.
- R4: A pull byte is read (mem_re = 1) from sp_out + 1, and the pointer then rises by one. The read data is taken from mem_rdata in the same cycle, so a push followed by a pull returns the same byte.
- R5: Interrupt entry writes exactly five bytes in this order: pc_in[7:0], pc_in[15:8], xl_in, acc_in, ccr_in. No high index byte is stored.
- R6: A call writes two bytes, pc_in[7:0] then pc_in[15:8]. A return pulls the high byte first, then the low byte, into pc_out.
- R7: Return from interrupt pulls five bytes in the reverse order of R5: condition codes, accumulator, index low, PC high, PC low. It restores ccr_out, acc_out, xl_out and pc_out.
- R8: done is 1 for exactly one cycle, the cycle after the last byte transfer. In that cycle busy is 0 and sp_out and the restored outputs hold their final values.
- R9: An access whose address lies outside 0x0060..0x045F sets range_err from the next cycle on. The access still takes place, and range_err stays set until a stack-pointer load.
- R10: When busy is 0, sp_load loads sp_load_val into the pointer on the next edge and clears range_err. sp_load wins over a simultaneous request, and it has no effect while busy is 1.
- R11: A push or pull request moves the accumulator: push writes acc_in, and pull restores acc_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Request type (see R2) |
| pc_in | input | 16 | Program counter to save |
| acc_in | input | 8 | Accumulator to save |
| xl_in | input | 8 | Index low byte to save |
| ccr_in | input | 8 | Condition codes to save |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 16 | New stack pointer value |
| mem_rdata | input | 8 | Read data from memory, valid in the read cycle |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pc_out | output | 16 | Restored program counter |
| acc_out | output | 8 | Restored accumulator |
| xl_out | output | 8 | Restored index low |
| ccr_out | output | 8 | Restored condition codes |
| sp_out | output | 16 | Current stack pointer |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Sticky out-of-window access flag |

## Verification
A wrong step count or frame kind shows up at once on the memory port. The address, strobe or write byte of that very transfer cycle differs from the expected transaction, or a transfer appears when none is expected. A pointer that is off by one is visible in the address of the next transfer. It also shows in sp_out in the done cycle. A wrong pull slot first appears in the restored outputs during the done cycle. A range flag that is set or cleared wrongly shows on range_err one cycle after the offending access or load.

// File: rtl/stk_pkg.sv
package stk_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter int STEP_W = 3;

  typedef enum logic [2:0] {
    K_NONE = 3'd0, K_CALL = 3'd1, K_RET = 3'd2, K_IRQ = 3'd3,
    K_RTI  = 3'd4, K_PUSH = 3'd5, K_PULL = 3'd6, K_RSVD = 3'd7
  } kind_e;

  typedef enum logic [2:0] {
    SL_PCL = 3'd0, SL_PCH = 3'd1, SL_X = 3'd2, SL_A = 3'd3, SL_CCR = 3'd4
  } slot_e;

  function automatic logic [STEP_W-1:0] frame_len(input kind_e k);
    case (k)
      K_CALL, K_RET: frame_len = STEP_W'(2);
      K_IRQ, K_RTI:  frame_len = STEP_W'(5);
      K_PUSH, K_PULL: frame_len = STEP_W'(1);
      default:       frame_len = '0;
    endcase
  endfunction

  function automatic logic is_pull(input kind_e k);
    is_pull = (k == K_RET) || (k == K_RTI) || (k == K_PULL);
  endfunction

  function automatic slot_e slot_of(input kind_e k, input logic [STEP_W-1:0] step);
    slot_of = SL_A;
    case (k)
      K_CALL: slot_of = (step == 0) ? SL_PCL : SL_PCH;
      K_RET:  slot_of = (step == 0) ? SL_PCH : SL_PCL;
      K_IRQ: begin
        case (step)
          3'd0: slot_of = SL_PCL;
          3'd1: slot_of = SL_PCH;
          3'd2: slot_of = SL_X;
          3'd3: slot_of = SL_A;
          default: slot_of = SL_CCR;
        endcase
      end
      K_RTI: begin
        case (step)
          3'd0: slot_of = SL_CCR;
          3'd1: slot_of = SL_A;
          3'd2: slot_of = SL_X;
          3'd3: slot_of = SL_PCH;
          default: slot_of = SL_PCL;
        endcase
      end
      default: slot_of = SL_A;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] access_addr(input logic [ADDR_W-1:0] sp,
                                                    input logic pull);
    access_addr = pull ? sp + ADDR_W'(1) : sp;
  endfunction

  function automatic logic [ADDR_W-1:0] sp_after(input logic [ADDR_W-1:0] sp,
                                                 input logic pull);
    sp_after = pull ? sp + ADDR_W'(1) : sp - ADDR_W'(1);
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    in_window = (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF,
  parameter logic [ADDR_W-1:0] WIN_LO   = 16'h0060,
  parameter logic [ADDR_W-1:0] WIN_HI   = 16'h045F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  input  logic              step_pull,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] sp,
  output logic              range_err
);
  logic bad_access;
  assign bad_access = step_en && !in_window(acc_addr, WIN_LO, WIN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= SP_RESET;
      range_err <= 1'b0;
    end else begin
      if (load_en) begin
        sp        <= load_val;
        range_err <= 1'b0;
      end else begin
        if (step_en)    sp <= sp_after(sp, step_pull);
        if (bad_access) range_err <= 1'b1;
      end
    end
  end

  p_range_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_access && !load_en) |=> range_err);
  p_range_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (range_err && !load_en) |=> range_err);
  p_sp_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sp == $past(load_val)) && !range_err);
  p_sp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(sp));
endmodule

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              sp_load,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output kind_e             kind_q,
  output logic [STEP_W-1:0] step_q,
  output logic              xfer_pull,
  output logic              last_step
);
  kind_e req_k;
  assign req_k     = kind_e'(req_kind);
  assign accept    = req_valid && !busy && !sp_load && (frame_len(req_k) != '0);
  assign xfer_pull = is_pull(kind_q);
  assign last_step = busy && (step_q == frame_len(kind_q) - STEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      kind_q <= K_NONE;
      step_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        kind_q <= req_k;
        step_q <= '0;
      end else if (busy) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done && !busy);
  p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(kind_q));
endmodule

// File: rtl/stk_restore.sv
module stk_restore
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] xl_out,
  output logic [DATA_W-1:0] ccr_out
);
  localparam int PCH_LO = ADDR_W - DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out  <= '0;
      acc_out <= '0;
      xl_out  <= '0;
      ccr_out <= '0;
    end else if (wr_en) begin
      case (slot)
        SL_PCL: pc_out[DATA_W-1:0]      <= rdata;
        SL_PCH: pc_out[ADDR_W-1:PCH_LO] <= rdata;
        SL_X:   xl_out                  <= rdata;
        SL_A:   acc_out                 <= rdata;
        default: ccr_out                <= rdata;
      endcase
    end
  end

  p_restore_only_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pc_out) && $stable(acc_out) && $stable(xl_out) && $stable(ccr_out));
endmodule

// File: rtl/stk_frame_seq.sv
module stk_frame_seq
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF,
  parameter logic [ADDR_W-1:0] WIN_LO   = 16'h0060,
  parameter logic [ADDR_W-1:0] WIN_HI   = 16'h045F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] xl_in,
  input  logic [DATA_W-1:0] ccr_in,
  input  logic              sp_load,
  input  logic [ADDR_W-1:0] sp_load_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] xl_out,
  output logic [DATA_W-1:0] ccr_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              busy,
  output logic              done,
  output logic              range_err
);
  localparam int PCH_LO = ADDR_W - DATA_W;

  logic              accept, xfer_pull, last_step, load_en;
  kind_e             kind_q;
  logic [STEP_W-1:0] step_q;
  slot_e             cur_slot;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] a_q, x_q, c_q;

  stk_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .sp_load(sp_load), .accept(accept), .busy(busy), .done(done),
    .kind_q(kind_q), .step_q(step_q), .xfer_pull(xfer_pull), .last_step(last_step)
  );

  assign load_en  = sp_load && !busy;
  assign cur_slot = slot_of(kind_q, step_q);
  assign mem_addr = access_addr(sp_out, xfer_pull);
  assign mem_we   = busy && !xfer_pull;
  assign mem_re   = busy && xfer_pull;

  stk_ptr #(.SP_RESET(SP_RESET), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(sp_load_val),
    .step_en(busy), .step_pull(xfer_pull), .acc_addr(mem_addr),
    .sp(sp_out), .range_err(range_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      a_q  <= '0;
      x_q  <= '0;
      c_q  <= '0;
    end else if (accept) begin
      pc_q <= pc_in;
      a_q  <= acc_in;
      x_q  <= xl_in;
      c_q  <= ccr_in;
    end
  end

  always_comb begin
    case (cur_slot)
      SL_PCL:  mem_wdata = pc_q[DATA_W-1:0];
      SL_PCH:  mem_wdata = pc_q[ADDR_W-1:PCH_LO];
      SL_X:    mem_wdata = x_q;
      SL_A:    mem_wdata = a_q;
      default: mem_wdata = c_q;
    endcase
  end

  stk_restore u_rest (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_re), .slot(cur_slot), .rdata(mem_rdata),
    .pc_out(pc_out), .acc_out(acc_out), .xl_out(xl_out), .ccr_out(ccr_out)
  );

  always_comb begin
    p_strobe_excl_r3: assert ($onehot0({mem_we, mem_re}));
  end
  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == $past(mem_addr) - ADDR_W'(1));
  p_pull_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_out == $past(mem_addr));
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/stk_frame_seq_tb_top.sv
module stk_frame_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, sp_load = 0;
  logic [2:0]  req_kind = 0;
  logic [15:0] pc_in = 0, sp_load_val = 0;
  logic [7:0]  acc_in = 0, xl_in = 0, ccr_in = 0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic [7:0]  mem_wdata, acc_out, xl_out, ccr_out;
  logic        mem_we, mem_re, busy, done, range_err;

  stk_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .pc_in(pc_in), .acc_in(acc_in), .xl_in(xl_in), .ccr_in(ccr_in),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pc_out(pc_out), .acc_out(acc_out), .xl_out(xl_out), .ccr_out(ccr_out),
    .sp_out(sp_out), .busy(busy), .done(done), .range_err(range_err)
  );

  logic [7:0] mem [0:2047];
  logic [7:0] shadow [0:2047];
  assign mem_rdata = mem[mem_addr[10:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;

  typedef struct packed { logic we; logic [15:0] addr; logic [7:0] data; } xfer_t;
  xfer_t q[$];

  int checks = 0, fails = 0;
  logic [15:0] exp_sp, exp_pc;
  logic [7:0]  exp_a, exp_x, exp_c;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every strobe cycle is compared with the scoreboard front
  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re)) begin
      xfer_t e;
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected transfer", {15'd0, mem_we, mem_addr}, 32'd0);
      end else begin
        e = q.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
            "R3/R4/R5/R6/R7/R11 transfer",
            {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, e.we, e.addr, e.data});
      end
    end
  end

  task automatic put(input logic [7:0] b);
    q.push_back({1'b1, exp_sp, b});
    shadow[exp_sp[10:0]] = b;
    exp_sp = exp_sp - 16'd1;
  endtask

  function automatic logic [7:0] get();
    exp_sp = exp_sp + 16'd1;
    q.push_back({1'b0, exp_sp, 8'h00});
    return shadow[exp_sp[10:0]];
  endfunction

  task automatic start(input logic [2:0] k, input logic [15:0] pc,
                       input logic [7:0] a, input logic [7:0] x, input logic [7:0] c);
    case (k)
      3'd1: begin put(pc[7:0]); put(pc[15:8]); end
      3'd2: begin exp_pc[15:8] = get(); exp_pc[7:0] = get(); end
      3'd3: begin put(pc[7:0]); put(pc[15:8]); put(x); put(a); put(c); end
      3'd4: begin exp_c = get(); exp_a = get(); exp_x = get();
                  exp_pc[15:8] = get(); exp_pc[7:0] = get(); end
      3'd5: put(a);
      3'd6: exp_a = get();
      default: ;
    endcase
    req_valid = 1; req_kind = k; pc_in = pc; acc_in = a; xl_in = x; ccr_in = c;
    @(negedge clk);
    req_valid = 0; req_kind = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk(done == 1'b1, {tag, " done seen"}, {31'd0, done}, 1);
    chk(busy == 1'b0, "R8 busy low at done", {31'd0, busy}, 0);
    chk(sp_out == exp_sp, {tag, " sp at done"}, {16'd0, sp_out}, {16'd0, exp_sp});
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", {31'd0, done}, 0);
  endtask

  task automatic load_sp(input logic [15:0] v);
    sp_load = 1; sp_load_val = v;
    @(negedge clk);
    sp_load = 0;
    exp_sp = v;
    chk(sp_out == v, "R10 sp load", {16'd0, sp_out}, {16'd0, v});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    exp_sp = 16'h00FF; exp_pc = 0; exp_a = 0; exp_x = 0; exp_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sp_out == 16'h00FF, "R1 sp reset", {16'd0, sp_out}, 32'h00FF);
    chk({busy, done, mem_we, mem_re, range_err} == 5'b0, "R1 idle flags",
        {27'd0, busy, done, mem_we, mem_re, range_err}, 0);

    // R6 call then return
    start(3'd1, 16'h1234, 8'h00, 8'h00, 8'h00);
    wait_done("R6 call");
    start(3'd2, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done("R6 ret");
    chk(pc_out == 16'h1234, "R6 pc restored", {16'd0, pc_out}, 32'h1234);

    // R5 interrupt entry, with R2 requests and a load raised while busy
    start(3'd3, 16'hABCD, 8'h22, 8'h11, 8'h33);
    req_valid = 1; req_kind = 3'd5; sp_load = 1; sp_load_val = 16'h0300;
    repeat (2) @(negedge clk);
    req_valid = 0; req_kind = 0; sp_load = 0;
    wait_done("R5 irq R2 ignore");

    // R7 return from interrupt
    start(3'd4, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done("R7 rti");
    chk(ccr_out == 8'h33, "R7 ccr", {24'd0, ccr_out}, {24'd0, exp_c});
    chk(acc_out == 8'h22, "R7 acc", {24'd0, acc_out}, {24'd0, exp_a});
    chk(xl_out == 8'h11, "R7 xl", {24'd0, xl_out}, {24'd0, exp_x});
    chk(pc_out == 16'hABCD, "R7 pc", {16'd0, pc_out}, {16'd0, exp_pc});

    // R11 single push/pull, R4 same byte returned
    start(3'd5, 16'h0000, 8'h5A, 8'h00, 8'h00);
    wait_done("R11 push");
    start(3'd6, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done("R4 pull");
    chk(acc_out == 8'h5A, "R4 R11 pulled byte", {24'd0, acc_out}, 32'h5A);

    // R2 reserved kind does nothing
    start(3'd7, 16'h0000, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && sp_out == exp_sp, "R2 reserved kind", {16'd0, sp_out}, {16'd0, exp_sp});

    // R10 load beats a simultaneous request
    sp_load = 1; sp_load_val = 16'h0200; req_valid = 1; req_kind = 3'd1;
    @(negedge clk);
    sp_load = 0; req_valid = 0; req_kind = 0; exp_sp = 16'h0200;
    repeat (3) @(negedge clk);
    chk(sp_out == 16'h0200 && !busy, "R10 load wins", {16'd0, sp_out}, 32'h0200);

    // R9 lower window edge
    load_sp(16'h0060);
    start(3'd5, 16'h0000, 8'h77, 8'h00, 8'h00);
    wait_done("R9 push at 0x60");
    chk(range_err == 1'b0, "R9 in window", {31'd0, range_err}, 0);
    start(3'd5, 16'h0000, 8'h78, 8'h00, 8'h00);
    wait_done("R9 push at 0x5F");
    chk(range_err == 1'b1, "R9 below window", {31'd0, range_err}, 1);
    start(3'd6, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done("R9 pull back");
    chk(acc_out == 8'h78 && range_err, "R9 sticky and data", {23'd0, range_err, acc_out}, 32'h178);

    // R9 upper window edge, load clears the flag
    load_sp(16'h045F);
    chk(range_err == 1'b0, "R10 load clears flag", {31'd0, range_err}, 0);
    start(3'd6, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done("R9 pull at 0x460");
    chk(range_err == 1'b1, "R9 above window", {31'd0, range_err}, 1);

    // R3 back-to-back interrupt frames mid RAM
    load_sp(16'h0400);
    start(3'd3, 16'h8001, 8'hA5, 8'h5A, 8'hC3);
    wait_done("R3 irq at 0x400");
    start(3'd4, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done("R7 rti at 0x400");
    chk(pc_out == 16'h8001 && acc_out == 8'hA5, "R7 second frame",
        {pc_out, acc_out, 8'd0}, {16'h8001, 8'hA5, 8'd0});

    chk(q.size() == 0, "R3 all transfers seen", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule